// File: doc/BRIEF.md
# Display Channel Mode Controller and EDID Streamer

This block runs one display data channel. Out of reset it is in a one-way streaming mode. Each rising edge of the vertical sync input moves the data line on by one bit. The bits come from the first 128 bytes of a dual-port EDID RAM, through the block's synchronous read port. Each byte goes out as a nine-bit packet: eight data bits, most significant first, then a separator bit that is always 1. The data line is open-drain, so the block only ever pulls it low or releases it. A software enable decides whether streaming drives the line at all.

The block watches the bus clock line. A falling edge on it moves the block into bidirectional I2C mode, where an external slave engine owns the bus. If the clock line then stays high for a whole timeout of vertical sync periods, the block falls back to streaming and restarts at the first bit of byte 0. When the slave engine reports an address of the form 1010xxx, the block locks into I2C mode, and only a reset releases the lock. A status flag is set on entry to I2C mode. Software can clear it, and the block clears it when it falls back to streaming.

The sync and clock inputs are asynchronous. Each passes through a two-flop synchronizer before its edges are detected in the system clock domain.

Top module: `ddc_mode_streamer`

## Requirements
- R1: While reset is asserted and after it ends, the block is in streaming mode with `i2c_mode`, `ddc2_flag` and `locked` at 0 and `ram_addr` at 0. During reset `sda_drive_low` is 0.
- R2: In streaming mode with the enable set, each vertical sync rising edge advances one bit. Data bits leave most significant first. `sda_drive_low` is 1 exactly when the current bit is 0.
- R3: After bit 0 (the eighth data bit) of each byte, a ninth separator bit of value 1 is sent, with the line released.
- R4: The RAM read address starts at 0 and increments once per byte, as the separator begins. It wraps from 127 to 0.
- R5: With `stream_en` at 0 the data line is released and sync edges do not advance the bit position. On re-enable, the stream resumes at the bit where it stopped.
- R6: A falling edge on the clock line in streaming mode enters I2C mode, sets `ddc2_flag` and releases the data line.
- R7: In unlocked I2C mode, the 128th vertical sync rising edge seen with the clock line continuously high returns the block to streaming. The 127th edge does not. On return, `ddc2_flag` clears and streaming restarts at bit 7 of RAM byte 0.
- R8: Any low level on the clock line during I2C mode restarts the timeout count from zero.
- R9: An `addr_strobe` with `addr_byte` matching 1010xxx during I2C mode sets `locked`. Once locked, the block stays in I2C mode regardless of sync edges until reset. Non-matching addresses, and any address strobed in streaming mode, leave `locked` at 0.
- R10: A `flag_clr` pulse clears `ddc2_flag` without leaving I2C mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| vsync_in | input | 1 | Asynchronous vertical sync, the stream bit clock |
| scl_in | input | 1 | Asynchronous bus clock line level |
| stream_en | input | 1 | Software enable for streaming output |
| flag_clr | input | 1 | Software write of 0 to the I2C-mode flag (one-cycle pulse) |
| addr_strobe | input | 1 | Slave engine reports a received 7-bit address |
| addr_byte | input | 7 | The received address |
| ram_rdata | input | 8 | EDID RAM read data, one cycle after `ram_addr` |
| ram_addr | output | 7 | EDID RAM read address |
| sda_drive_low | output | 1 | 1 pulls the open-drain data line low |
| i2c_mode | output | 1 | 1 while in I2C mode |
| ddc2_flag | output | 1 | Software-clearable I2C-mode status flag |
| locked | output | 1 | I2C mode locked by a matching address |

## Verification
The bench checks every bit of 130 consecutive packets against the RAM image. A design that shifts LSB first, drops the separator or fails to wrap the address would mismatch on the first byte or at byte 128. The timeout is probed on both sides of its limit, at 127 and 128 edges. A reset of the count on a clock-line low is also tested, so an off-by-one counter or a count that ignores the clock line returns to streaming at the wrong edge. The bench also strobes a matching address in streaming mode, and a non-matching and then a matching address in I2C mode. A design that locks on the wrong address, or times out while locked, shows the wrong `locked` or `i2c_mode` level.

// File: rtl/ddc_pkg.sv
package ddc_pkg;
  typedef enum logic {
    MODE_STREAM = 1'b0,
    MODE_I2C    = 1'b1
  } ddc_mode_e;
endpackage

// File: rtl/ddc_edge_sync.sv
module ddc_edge_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic lvl,
  output logic lvl_d
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr    <= {STAGES{RST_VAL}};
      lvl_d <= RST_VAL;
    end else begin
      sr    <= {sr[STAGES-2:0], din};
      lvl_d <= sr[STAGES-1];
    end
  end

  assign lvl = sr[STAGES-1];
endmodule

// File: rtl/ddc_serializer.sv
module ddc_serializer #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              active,
  input  logic              en,
  input  logic              tick,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              sda_low
);
  localparam int BIT_W = $clog2(DATA_W + 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);
  localparam logic [BIT_W-1:0] SEP_BIT  = BIT_W'(DATA_W);

  logic [ADDR_W-1:0] ptr;
  logic [BIT_W-1:0]  bit_q;
  logic [DATA_W-1:0] byte_q;
  logic [DATA_W-1:0] shifted;
  logic              cur_bit;
  logic              adv;

  assign adv = tick & active & en;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      ptr   <= '0;
      bit_q <= '0;
    end else if (adv) begin
      if (bit_q == SEP_BIT) begin
        bit_q <= '0;
      end else if (bit_q == LAST_BIT) begin
        bit_q <= SEP_BIT;
        ptr   <= ptr + 1'b1;
      end else begin
        bit_q <= bit_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) byte_q <= '0;
    else     byte_q <= ram_rdata;
  end

  assign shifted = byte_q << bit_q;
  assign cur_bit = (bit_q == SEP_BIT) ? 1'b1 : shifted[DATA_W-1];

  always_ff @(posedge clk) begin
    if (rst) sda_low <= 1'b0;
    else     sda_low <= active & en & ~cur_bit;
  end

  assign ram_addr = ptr;

  p_bit_range_r3: assert property (@(posedge clk) disable iff (rst)
    bit_q <= SEP_BIT);
  p_addr_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (adv && bit_q == LAST_BIT && ptr == {ADDR_W{1'b1}}) |=> (ptr == '0));
  p_release_r5: assert property (@(posedge clk) disable iff (rst)
    (!en || !active) |=> !sda_low);
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!en && !restart) |=> ($stable(ptr) && $stable(bit_q)));
endmodule

// File: rtl/ddc_mode_fsm.sv
module ddc_mode_fsm
  import ddc_pkg::*;
#(
  parameter int         TIMEOUT    = 128,
  parameter logic [6:0] LOCK_MASK  = 7'b1111000,
  parameter logic [6:0] LOCK_MATCH = 7'b1010000
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      vs_rise,
  input  logic      scl_lvl,
  input  logic      scl_fall,
  input  logic      flag_clr,
  input  logic      addr_strobe,
  input  logic [6:0] addr_byte,
  output ddc_mode_e mode,
  output logic      to_stream,
  output logic      flag,
  output logic      locked
);
  localparam int CNT_W = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT - 1);

  logic [CNT_W-1:0] cnt;
  logic             enter_i2c;
  logic             addr_hit;

  assign enter_i2c = (mode == MODE_STREAM) && scl_fall;
  assign to_stream = (mode == MODE_I2C) && !locked && scl_lvl && vs_rise && (cnt == CNT_LAST);
  assign addr_hit  = addr_strobe && (mode == MODE_I2C) && ((addr_byte & LOCK_MASK) == LOCK_MATCH);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= MODE_STREAM;
    end else if (enter_i2c) begin
      mode <= MODE_I2C;
    end else if (to_stream) begin
      mode <= MODE_STREAM;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || mode == MODE_STREAM || !scl_lvl || to_stream) begin
      cnt <= '0;
    end else if (vs_rise && cnt != CNT_LAST) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           locked <= 1'b0;
    else if (addr_hit) locked <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                       flag <= 1'b0;
    else if (enter_i2c)            flag <= 1'b1;
    else if (to_stream || flag_clr) flag <= 1'b0;
  end

  p_enter_i2c_r6: assert property (@(posedge clk) disable iff (rst)
    enter_i2c |=> (mode == MODE_I2C && flag));
  p_cnt_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_STREAM) |-> (cnt == '0));
  p_scl_low_r8: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_I2C && !scl_lvl) |=> (cnt == '0));
  p_lock_hold_r9: assert property (@(posedge clk) disable iff (rst)
    locked |=> (locked && mode == MODE_I2C));
  p_flag_clr_r10: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && !enter_i2c) |=> !flag);
endmodule

// File: rtl/ddc_mode_streamer.sv
module ddc_mode_streamer
  import ddc_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int TIMEOUT     = 128,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vsync_in,
  input  logic              scl_in,
  input  logic              stream_en,
  input  logic              flag_clr,
  input  logic              addr_strobe,
  input  logic [6:0]        addr_byte,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              sda_drive_low,
  output logic              i2c_mode,
  output logic              ddc2_flag,
  output logic              locked
);
  logic      vs_lvl, vs_lvl_d, scl_lvl, scl_lvl_d;
  logic      vs_rise, scl_fall, to_stream;
  ddc_mode_e mode;

  ddc_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_vs_sync (
    .clk(clk), .rst(rst), .din(vsync_in), .lvl(vs_lvl), .lvl_d(vs_lvl_d));

  ddc_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
    .clk(clk), .rst(rst), .din(scl_in), .lvl(scl_lvl), .lvl_d(scl_lvl_d));

  assign vs_rise  = vs_lvl & ~vs_lvl_d;
  assign scl_fall = ~scl_lvl & scl_lvl_d;

  ddc_mode_fsm #(.TIMEOUT(TIMEOUT)) u_fsm (
    .clk(clk), .rst(rst), .vs_rise(vs_rise), .scl_lvl(scl_lvl), .scl_fall(scl_fall),
    .flag_clr(flag_clr), .addr_strobe(addr_strobe), .addr_byte(addr_byte),
    .mode(mode), .to_stream(to_stream), .flag(ddc2_flag), .locked(locked));

  ddc_serializer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ser (
    .clk(clk), .rst(rst), .restart(to_stream), .active(mode == MODE_STREAM),
    .en(stream_en), .tick(vs_rise), .ram_rdata(ram_rdata),
    .ram_addr(ram_addr), .sda_low(sda_drive_low));

  assign i2c_mode = (mode == MODE_I2C);

  p_i2c_release_r6: assert property (@(posedge clk) disable iff (rst)
    i2c_mode |=> !sda_drive_low);
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (!i2c_mode && !ddc2_flag && !locked && ram_addr == '0 && !sda_drive_low));
endmodule

// File: tb/tb_ddc_mode_streamer.sv
module tb_ddc_mode_streamer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       vsync_in = 1'b0;
  logic       scl_in = 1'b1;
  logic       stream_en = 1'b1;
  logic       flag_clr = 1'b0;
  logic       addr_strobe = 1'b0;
  logic [6:0] addr_byte = '0;
  logic [7:0] ram_rdata;
  logic [6:0] ram_addr;
  logic       sda_drive_low, i2c_mode, ddc2_flag, locked;

  int ntest = 0;
  int nfail = 0;

  always #10 clk = ~clk;

  ddc_mode_streamer dut (
    .clk(clk), .rst(rst), .vsync_in(vsync_in), .scl_in(scl_in), .stream_en(stream_en),
    .flag_clr(flag_clr), .addr_strobe(addr_strobe), .addr_byte(addr_byte),
    .ram_rdata(ram_rdata), .ram_addr(ram_addr), .sda_drive_low(sda_drive_low),
    .i2c_mode(i2c_mode), .ddc2_flag(ddc2_flag), .locked(locked));

  function automatic logic [7:0] edid(input int a);
    logic [7:0] x;
    x = a[7:0];
    return (x * 8'd37 + 8'h5A) ^ {1'b0, x[7:1]};
  endfunction

  always_ff @(posedge clk) ram_rdata <= edid(int'(ram_addr));

  function automatic logic exp_low(input int k);
    int         j;
    logic [7:0] b;
    j = k % 9;
    b = edid((k / 9) % 128);
    return (j == 8) ? 1'b0 : ~b[7 - j];
  endfunction

  function automatic int exp_addr(input int k);
    return ((k / 9) + ((k % 9 == 8) ? 1 : 0)) % 128;
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    ntest++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      vsync_in = 1'b1; cyc(6);
      vsync_in = 1'b0; cyc(6);
    end
  endtask

  task automatic scl_dip();
    scl_in = 1'b0; cyc(6);
    scl_in = 1'b1; cyc(6);
  endtask

  task automatic strobe(input logic [6:0] a);
    addr_byte = a; addr_strobe = 1'b1; cyc(1);
    addr_strobe = 1'b0; cyc(4);
  endtask

  task automatic do_reset();
    rst = 1'b1; scl_in = 1'b1; vsync_in = 1'b0; stream_en = 1'b1; cyc(4);
    chk(!sda_drive_low && !i2c_mode && !ddc2_flag && !locked && ram_addr == 0,
        "R1 during reset", int'(sda_drive_low), 0);
    rst = 1'b0; cyc(5);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end

  initial begin
    int k;
    cyc(1);
    do_reset();
    chk(!i2c_mode && !ddc2_flag && !locked, "R1 mode after reset", int'(i2c_mode), 0);
    chk(ram_addr == 0, "R1 address after reset", int'(ram_addr), 0);

    // R2 R3 R4: every bit of 130 packets, across the 127->0 wrap
    for (k = 0; k < 1170; k++) begin
      chk(sda_drive_low == exp_low(k), "R2/R3 stream bit", int'(sda_drive_low), int'(exp_low(k)));
      chk(int'(ram_addr) == exp_addr(k), "R4 read address", int'(ram_addr), exp_addr(k));
      pulse(1);
    end

    // R5: disabled stream releases the line and holds position
    stream_en = 1'b0; cyc(4);
    for (int i = 0; i < 3; i++) begin
      chk(!sda_drive_low, "R5 released while disabled", int'(sda_drive_low), 0);
      pulse(1);
    end
    chk(int'(ram_addr) == exp_addr(k), "R5 address held", int'(ram_addr), exp_addr(k));
    stream_en = 1'b1; cyc(4);
    chk(sda_drive_low == exp_low(k), "R5 resume bit", int'(sda_drive_low), int'(exp_low(k)));
    pulse(1); k++;
    chk(sda_drive_low == exp_low(k), "R5 next bit", int'(sda_drive_low), int'(exp_low(k)));

    // R9: matching address in streaming mode is ignored
    strobe(7'h50);
    chk(!locked, "R9 strobe in stream mode", int'(locked), 0);

    // R6: clock-line fall enters I2C mode
    scl_dip();
    chk(i2c_mode && ddc2_flag, "R6 enter I2C", int'(i2c_mode), 1);
    chk(!sda_drive_low, "R6 line released", int'(sda_drive_low), 0);

    // R7: timeout boundary
    pulse(127);
    chk(i2c_mode, "R7 still I2C at 127", int'(i2c_mode), 1);
    pulse(1);
    chk(!i2c_mode, "R7 back to stream at 128", int'(i2c_mode), 0);
    chk(!ddc2_flag, "R7 flag cleared on return", int'(ddc2_flag), 0);
    chk(ram_addr == 0, "R7 address restart", int'(ram_addr), 0);
    chk(sda_drive_low == exp_low(0), "R7 restart bit", int'(sda_drive_low), int'(exp_low(0)));
    pulse(1);
    chk(sda_drive_low == exp_low(1), "R7 second bit", int'(sda_drive_low), int'(exp_low(1)));

    // R8: a low level restarts the count
    scl_dip();
    chk(i2c_mode, "R8 enter I2C", int'(i2c_mode), 1);
    pulse(100);
    scl_dip();
    pulse(127);
    chk(i2c_mode, "R8 count restarted", int'(i2c_mode), 1);
    pulse(1);
    chk(!i2c_mode, "R8 timeout after restart", int'(i2c_mode), 0);

    // R10: software clear keeps I2C mode
    scl_dip();
    chk(ddc2_flag, "R10 flag set", int'(ddc2_flag), 1);
    flag_clr = 1'b1; cyc(1); flag_clr = 1'b0; cyc(3);
    chk(!ddc2_flag, "R10 flag cleared", int'(ddc2_flag), 0);
    chk(i2c_mode, "R10 mode kept", int'(i2c_mode), 1);

    // R9: lock only on 1010xxx
    strobe(7'h3C);
    chk(!locked, "R9 non-matching address", int'(locked), 0);
    strobe(7'h57);
    chk(locked, "R9 matching address locks", int'(locked), 1);
    pulse(200);
    chk(i2c_mode && locked, "R9 no timeout when locked", int'(i2c_mode), 1);

    do_reset();
    chk(!locked && !i2c_mode, "R1 reset clears lock", int'(locked), 0);

    $display("[TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end
endmodule